// File: doc/BRIEF.md
# Link-side request serializer

This block is the transmit half of the link layer's serial request channel toward the physical layer. A client hands it one command at a time over a valid/ready handshake. Each command becomes a fixed-length frame on a single request line, one bit per clock. A frame is a start bit, a 3-bit type code, the payload and a stop bit. There are six commands: register read, register write, acceleration control, and three bus requests (fair, priority and isochronous, each carrying a speed code).

The serializer watches the 2-bit interface control state driven by the physical layer. Fair and priority requests wait until the interface has been idle (`00`) for at least one full clock. If the receive state (`10`) appears while such a request is held or on the line, the request is lost. The block then pulses `req_lost`, drops the line and reissues the whole frame at the next legal time, with no help from the client. Isochronous requests wait until a cycle-start message has been seen (`cycle_start_evt`). Register and acceleration commands ignore the control state.

Internally a three-state machine sequences each command. `ST_IDLE` is ready for a command. `ST_HOLD` keeps the command until its start gate opens. `ST_SHIFT` drives the frame bits. The transitions are:
- IDLE→HOLD on accept.
- HOLD→SHIFT when the gate opens.
- SHIFT→IDLE after the stop bit.
- SHIFT→HOLD when a fair or priority frame is cancelled by receive.

HOLD stays in HOLD while the gate is closed.

Top module: `link_req_serializer`

## Requirements
- R1: A register read (cmd_kind 0) is sent as 9 bits: 1, type 100, the 4-bit address MSB first, then 0.
- R2: A register write (cmd_kind 1) is sent as 17 bits: 1, type 101, the address MSB first, the 8 data bits MSB first, then 0.
- R3: An acceleration control (cmd_kind 2) is sent as 6 bits: 1, type 110, the enable bit, then 0.
- R4: A bus request is sent as 8 bits: 1, the type, the 3-bit speed MSB first, then 0. The kinds and types are fair (cmd_kind 3, type 011), priority (cmd_kind 4, type 001) and isochronous (cmd_kind 5, type 010).
- R5: A command is taken on a clock edge where cmd_valid and cmd_ready are both high. cmd_ready is high only when no command is held or being sent, so it is low in the cycle after an accept.
- R6: The start bit of a fair or priority request is driven only after two consecutive clock edges have sampled ctl_state = 00. It appears in the cycle that follows the second such edge.
- R7: Register read, register write and acceleration commands are not affected by ctl_state. Their start bit is driven in the second cycle after the accepting edge, and a receive state does not cancel them.
- R8: If ctl_state is 10 while a fair or priority request is held or being shifted, req_lost pulses for one cycle per cancellation and the line is low in the next cycle. The complete frame is then resent from its start bit, under R6.
- R9: An isochronous request is held until a cycle_start_evt pulse has been seen since the last isochronous frame began (or since reset). The receive state does not cancel it.
- R10: req_line is low whenever no frame is being shifted, including after reset.
- R11: cmd_done pulses for exactly one cycle, in the cycle right after the stop bit, and cmd_ready is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Serializer can take a command |
| cmd_kind | input | 3 | 0 read, 1 write, 2 acceleration, 3 fair, 4 priority, 5 isochronous |
| cmd_addr | input | ADDR_W | Register address |
| cmd_data | input | DATA_W | Register write data |
| cmd_accel_en | input | 1 | Acceleration enable bit |
| cmd_speed | input | SPD_W | Bus request speed code |
| ctl_state | input | 2 | Interface control state (00 idle, 10 receive) |
| cycle_start_evt | input | 1 | One-cycle pulse: a cycle-start message was sent or received |
| req_line | output | 1 | Serial request bit stream |
| cmd_done | output | 1 | Pulse after the stop bit of a completed frame |
| req_lost | output | 1 | Pulse when a fair or priority request is cancelled |

## Verification
The bench builds the block with its default parameters: a 4-bit address, 8-bit data and a 3-bit speed code. With these values the write frame (17 bits) is the longest frame, so the bit counter runs its full range. The 8-bit bus request is shorter, so cancelling one partway through and restarting it from its stored copy can be observed across a complete frame. These values also make every frame short enough to check bit by bit against a frame the bench assembles from R1–R4.

// File: rtl/link_req_pkg.sv
package link_req_pkg;
    typedef enum logic [2:0] {
        K_READ  = 3'd0,
        K_WRITE = 3'd1,
        K_ACCEL = 3'd2,
        K_FAIR  = 3'd3,
        K_PRI   = 3'd4,
        K_ISO   = 3'd5
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_SHIFT
    } ser_state_e;

    localparam logic [2:0] TY_READ  = 3'b100;
    localparam logic [2:0] TY_WRITE = 3'b101;
    localparam logic [2:0] TY_ACCEL = 3'b110;
    localparam logic [2:0] TY_FAIR  = 3'b011;
    localparam logic [2:0] TY_PRI   = 3'b001;
    localparam logic [2:0] TY_ISO   = 3'b010;

    localparam logic [1:0] CTL_IDLE = 2'b00;
    localparam logic [1:0] CTL_RX   = 2'b10;

    function automatic logic is_cancellable(req_kind_e k);
        return (k == K_FAIR) || (k == K_PRI);
    endfunction
endpackage

// File: rtl/link_req_frame.sv
module link_req_frame
    import link_req_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int SPD_W   = 3,
    parameter int FRAME_W = 5 + ADDR_W + DATA_W,
    parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  req_kind_e           kind,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   data,
    input  logic                accel_en,
    input  logic [SPD_W-1:0]    speed,
    output logic [FRAME_W-1:0]  frame,
    output logic [LEN_W-1:0]    len
);
    localparam int RD_LEN  = 5 + ADDR_W;
    localparam int WR_LEN  = 5 + ADDR_W + DATA_W;
    localparam int ACC_LEN = 6;
    localparam int BUS_LEN = 5 + SPD_W;

    always_comb begin
        unique case (kind)
            K_WRITE: begin
                frame = FRAME_W'({1'b1, TY_WRITE, addr, data, 1'b0}) << (FRAME_W - WR_LEN);
                len   = LEN_W'(WR_LEN);
            end
            K_ACCEL: begin
                frame = FRAME_W'({1'b1, TY_ACCEL, accel_en, 1'b0}) << (FRAME_W - ACC_LEN);
                len   = LEN_W'(ACC_LEN);
            end
            K_FAIR: begin
                frame = FRAME_W'({1'b1, TY_FAIR, speed, 1'b0}) << (FRAME_W - BUS_LEN);
                len   = LEN_W'(BUS_LEN);
            end
            K_PRI: begin
                frame = FRAME_W'({1'b1, TY_PRI, speed, 1'b0}) << (FRAME_W - BUS_LEN);
                len   = LEN_W'(BUS_LEN);
            end
            K_ISO: begin
                frame = FRAME_W'({1'b1, TY_ISO, speed, 1'b0}) << (FRAME_W - BUS_LEN);
                len   = LEN_W'(BUS_LEN);
            end
            default: begin
                frame = FRAME_W'({1'b1, TY_READ, addr, 1'b0}) << (FRAME_W - RD_LEN);
                len   = LEN_W'(RD_LEN);
            end
        endcase
    end
endmodule

// File: rtl/link_req_monitor.sv
module link_req_monitor
    import link_req_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ctl_state,
    input  logic       cycle_start_evt,
    input  logic       iso_launch,
    output logic       idle_settled,
    output logic       rx_now,
    output logic       rx_rise,
    output logic       cs_armed
);
    logic rx_prev;

    assign rx_now  = (ctl_state == CTL_RX);
    assign rx_rise = rx_now && !rx_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_settled <= 1'b0;
            rx_prev      <= 1'b0;
        end else begin
            idle_settled <= (ctl_state == CTL_IDLE);
            rx_prev      <= rx_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cs_armed <= 1'b0;
        else if (cycle_start_evt)
            cs_armed <= 1'b1;
        else if (iso_launch)
            cs_armed <= 1'b0;
    end

    assert_iso_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        iso_launch |-> cs_armed);
endmodule

// File: rtl/link_req_serializer.sv
module link_req_serializer
    import link_req_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int SPD_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_accel_en,
    input  logic [SPD_W-1:0]  cmd_speed,
    input  logic [1:0]        ctl_state,
    input  logic              cycle_start_evt,
    output logic              req_line,
    output logic              cmd_done,
    output logic              req_lost
);
    localparam int FRAME_W = 5 + ADDR_W + DATA_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    ser_state_e           state, state_nx;
    req_kind_e            kind_q;
    logic [FRAME_W-1:0]   frame_new, frame_q, sreg;
    logic [LEN_W-1:0]     len_new, len_q, cnt;
    logic                 idle_settled, rx_now, rx_rise, cs_armed;
    logic                 gate_ok, cancel, last_bit, iso_launch, accept;

    link_req_frame #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPD_W(SPD_W),
        .FRAME_W(FRAME_W), .LEN_W(LEN_W)
    ) u_frame (
        .kind     (req_kind_e'(cmd_kind)),
        .addr     (cmd_addr),
        .data     (cmd_data),
        .accel_en (cmd_accel_en),
        .speed    (cmd_speed),
        .frame    (frame_new),
        .len      (len_new)
    );

    link_req_monitor u_mon (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctl_state       (ctl_state),
        .cycle_start_evt (cycle_start_evt),
        .iso_launch      (iso_launch),
        .idle_settled    (idle_settled),
        .rx_now          (rx_now),
        .rx_rise         (rx_rise),
        .cs_armed        (cs_armed)
    );

    assign cmd_ready = (state == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign req_line  = (state == ST_SHIFT) && sreg[FRAME_W-1];
    assign last_bit  = (cnt == '0);

    always_comb begin
        unique case (kind_q)
            K_FAIR, K_PRI: gate_ok = (ctl_state == CTL_IDLE) && idle_settled;
            K_ISO:         gate_ok = cs_armed;
            default:       gate_ok = 1'b1;
        endcase
        cancel = is_cancellable(kind_q) && rx_now;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_HOLD;
            ST_HOLD:  if (!cancel && gate_ok) state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (cancel)        state_nx = ST_HOLD;
                else if (last_bit) state_nx = ST_IDLE;
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    assign iso_launch = (state == ST_HOLD) && (state_nx == ST_SHIFT) && (kind_q == K_ISO);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_done <= 1'b0;
            req_lost <= 1'b0;
        end else begin
            cmd_done <= (state == ST_SHIFT) && last_bit && !cancel;
            req_lost <= is_cancellable(kind_q) &&
                        (((state == ST_HOLD) && rx_rise) || ((state == ST_SHIFT) && rx_now));
        end
    end

    // command store and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_READ;
            frame_q <= '0;
            len_q   <= '0;
            sreg    <= '0;
            cnt     <= '0;
        end else begin
            if (accept) begin
                kind_q  <= req_kind_e'(cmd_kind);
                frame_q <= frame_new;
                len_q   <= len_new;
            end
            if (state == ST_HOLD && state_nx == ST_SHIFT) begin
                sreg <= frame_q;
                cnt  <= len_q - LEN_W'(1);
            end else if (state == ST_SHIFT) begin
                sreg <= sreg << 1;
                cnt  <= cnt - LEN_W'(1);
            end
        end
    end

    assert_fair_start_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state) == ST_HOLD && is_cancellable(kind_q))
        |-> ($past(ctl_state) == CTL_IDLE && $past(ctl_state, 2) == CTL_IDLE));

    assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_lost_on_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_lost |-> ($past(ctl_state) == CTL_RX && !req_line));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (cmd_ready && !req_line) ##1 !cmd_done);

    assert_line_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !req_line);
endmodule

// File: tb/link_req_serializer_tb.sv
`timescale 1ns/1ps
module link_req_serializer_tb;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int SPD_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [2:0] cmd_kind = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic cmd_accel_en = 1'b0;
    logic [SPD_W-1:0] cmd_speed = '0;
    logic [1:0] ctl_state = 2'b00;
    logic cycle_start_evt = 1'b0;
    logic req_line, cmd_done, req_lost;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    link_req_serializer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPD_W(SPD_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_accel_en(cmd_accel_en), .cmd_speed(cmd_speed), .ctl_state(ctl_state),
        .cycle_start_evt(cycle_start_evt), .req_line(req_line),
        .cmd_done(cmd_done), .req_lost(req_lost)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one command; returns at the negedge after the accepting edge
    task automatic send(input int kind, input int addr, input int data, input bit en, input int spd);
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R5 ready before offer", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_kind = 3'(kind); cmd_addr = ADDR_W'(addr);
        cmd_data = DATA_W'(data); cmd_accel_en = en; cmd_speed = SPD_W'(spd);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R5 ready low after accept", cmd_ready, 0);
    endtask

    // wait for start bit, gather len bits, end at negedge after stop bit
    task automatic collect(input int len, output logic [31:0] bits, output int waited);
        waited = 0;
        bits = '0;
        while (!req_line && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        for (int i = 0; i < len; i++) begin
            bits = {bits[30:0], req_line};
            @(negedge clk);
        end
    endtask

    task automatic check_done(input string req);
        chk(cmd_done == 1'b1, {req, " R11 done pulse"}, cmd_done, 1);
        chk(cmd_ready == 1'b1, {req, " R11 ready with done"}, cmd_ready, 1);
        @(negedge clk);
        chk(cmd_done == 1'b0, {req, " R11 done single"}, cmd_done, 0);
        chk(req_line == 1'b0, {req, " R10 line low after frame"}, req_line, 0);
    endtask

    task automatic t_reset();
        chk(cmd_ready == 1'b1, "R5 reset ready", cmd_ready, 1);
        chk(req_line == 1'b0, "R10 reset line", req_line, 0);
        chk(cmd_done == 1'b0, "R11 reset done", cmd_done, 0);
        chk(req_lost == 1'b0, "R8 reset lost", req_lost, 0);
    endtask

    task automatic t_read();
        logic [31:0] b; int w;
        ctl_state = 2'b01;
        send(0, 4'hA, 0, 0, 0);
        collect(9, b, w);
        chk(w == 1, "R7 read start not gated", w, 1);
        chk(b[8:0] == {1'b1, 3'b100, 4'hA, 1'b0}, "R1 read frame", b[8:0], {1'b1, 3'b100, 4'hA, 1'b0});
        check_done("R1");
    endtask

    task automatic t_write();
        logic [31:0] b; int w;
        ctl_state = 2'b10;
        send(1, 4'h5, 8'hC3, 0, 0);
        collect(17, b, w);
        chk(w == 1, "R7 write start under receive", w, 1);
        chk(b[16:0] == {1'b1, 3'b101, 4'h5, 8'hC3, 1'b0}, "R2 write frame",
            b[16:0], {1'b1, 3'b101, 4'h5, 8'hC3, 1'b0});
        chk(req_lost == 1'b0, "R7 no loss for write", req_lost, 0);
        check_done("R2");
    endtask

    task automatic t_accel();
        logic [31:0] b; int w;
        ctl_state = 2'b10;
        send(2, 0, 0, 1, 0);
        collect(6, b, w);
        chk(w == 1, "R7 accel start", w, 1);
        chk(b[5:0] == 6'b111010, "R3 accel enable frame", b[5:0], 6'b111010);
        check_done("R3");
        ctl_state = 2'b00;
        send(2, 0, 0, 0, 0);
        collect(6, b, w);
        chk(b[5:0] == 6'b111000, "R3 accel disable frame", b[5:0], 6'b111000);
        check_done("R3");
    endtask

    task automatic t_fair_gate();
        logic [31:0] b; int w;
        ctl_state = 2'b01;
        send(3, 0, 0, 0, 3'b101);
        for (int i = 0; i < 4; i++) begin
            chk(req_line == 1'b0, "R6 fair held while busy", req_line, 0);
            @(negedge clk);
        end
        ctl_state = 2'b00;
        collect(8, b, w);
        chk(w == 2, "R6 fair start one clock after idle", w, 2);
        chk(b[7:0] == {1'b1, 3'b011, 3'b101, 1'b0}, "R4 fair frame", b[7:0], {1'b1, 3'b011, 3'b101, 1'b0});
        check_done("R4");
    endtask

    task automatic t_pri_cancel_shift();
        logic [31:0] b; int w;
        ctl_state = 2'b00;
        repeat (2) @(negedge clk);
        send(4, 0, 0, 0, 3'b110);
        w = 0;
        while (!req_line && w < 20) begin @(negedge clk); w++; end
        chk(w == 1, "R6 priority start after settled idle", w, 1);
        repeat (3) @(negedge clk);
        ctl_state = 2'b10;
        @(negedge clk);
        chk(req_lost == 1'b1, "R8 lost pulse in shift", req_lost, 1);
        chk(req_line == 1'b0, "R8 line low after cancel", req_line, 0);
        @(negedge clk);
        chk(req_lost == 1'b0, "R8 lost single pulse", req_lost, 0);
        ctl_state = 2'b00;
        collect(8, b, w);
        chk(w == 2, "R8 reissue timing", w, 2);
        chk(b[7:0] == {1'b1, 3'b001, 3'b110, 1'b0}, "R4 R8 priority frame resent",
            b[7:0], {1'b1, 3'b001, 3'b110, 1'b0});
        check_done("R8");
    endtask

    task automatic t_fair_cancel_hold();
        logic [31:0] b; int w;
        ctl_state = 2'b01;
        send(3, 0, 0, 0, 3'b010);
        ctl_state = 2'b10;
        @(negedge clk);
        chk(req_lost == 1'b1, "R8 lost pulse while held", req_lost, 1);
        @(negedge clk);
        chk(req_lost == 1'b0, "R8 one pulse per cancel", req_lost, 0);
        chk(req_line == 1'b0, "R8 line low while receive", req_line, 0);
        ctl_state = 2'b00;
        collect(8, b, w);
        chk(w == 2, "R8 R6 resend after idle", w, 2);
        chk(b[7:0] == {1'b1, 3'b011, 3'b010, 1'b0}, "R8 fair frame", b[7:0], {1'b1, 3'b011, 3'b010, 1'b0});
        check_done("R8");
    endtask

    task automatic t_iso();
        logic [31:0] b; int w;
        ctl_state = 2'b00;
        send(5, 0, 0, 0, 3'b011);
        for (int i = 0; i < 5; i++) begin
            chk(req_line == 1'b0, "R9 iso held without cycle start", req_line, 0);
            @(negedge clk);
        end
        cycle_start_evt = 1'b1;
        @(negedge clk);
        cycle_start_evt = 1'b0;
        collect(8, b, w);
        chk(w == 1, "R9 iso starts after cycle start", w, 1);
        chk(b[7:0] == {1'b1, 3'b010, 3'b011, 1'b0}, "R4 iso frame", b[7:0], {1'b1, 3'b010, 3'b011, 1'b0});
        check_done("R9");
        // second iso needs a fresh cycle start; receive must not cancel it
        send(5, 0, 0, 0, 3'b001);
        ctl_state = 2'b10;
        for (int i = 0; i < 4; i++) begin
            chk(req_line == 1'b0, "R9 second iso held", req_line, 0);
            chk(req_lost == 1'b0, "R9 iso not lost on receive", req_lost, 0);
            @(negedge clk);
        end
        cycle_start_evt = 1'b1;
        @(negedge clk);
        cycle_start_evt = 1'b0;
        collect(8, b, w);
        chk(b[7:0] == {1'b1, 3'b010, 3'b001, 1'b0}, "R9 second iso frame", b[7:0], {1'b1, 3'b010, 3'b001, 1'b0});
        check_done("R9");
        ctl_state = 2'b00;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read();
        t_write();
        t_accel();
        t_fair_gate();
        t_pri_cancel_shift();
        t_fair_cancel_hold();
        t_iso();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule